// File: doc/BRIEF.md
# Buck Converter Overcurrent Blanking and Hiccup Fault Manager

This block holds the fault logic of a synchronous buck PWM controller. It sits between the pulse-width modulator and the gate drivers. It sees one end-of-period strobe per switching cycle, the raw high-side request and four fault inputs. From these it produces the gate enables that actually reach the drivers. A low-side overcurrent comparator is watched across each whole period. If the comparator fires at any point in that period, the next high-side pulse is suppressed, while the low-side gate keeps switching as the complement of the request. This limits the inductor peak current one cycle at a time.

When overcurrent persists for a run of consecutive periods, or the under-voltage comparator stays asserted past a filter time after soft-start has finished, both gates are forced off. A hiccup off-time then follows, and after it a one-clock restart request goes to the startup sequencer. Overcurrent restarts are limited in number: once the allowance is used up, the next overcurrent trip latches the block off. Under-voltage trips always restart. An over-temperature flag latches the block off at once from any state. Only the power-on reset clears the latched state.

Top module: `buck_fault_mgr`

## Requirements
- R1: An overcurrent event is the comparator high on any clock of a period, the strobe clock included. An event blocks the high-side enable for every clock of the following period. A period that follows an event-free period passes the high-side request unchanged.
- R2: While running, the low-side enable equals the inverse of the high-side request, whether or not high-side blocking is active.
- R3: The high-side and low-side enables are never high together. Both are low in every clock outside the running state.
- R4: When OC_TRIP_CNT consecutive periods each carry an overcurrent event, the block trips at the strobe that ends the last of them. Both gates are low from the next clock. A shorter run followed by an event-free period does not trip.
- R5: A hiccup holds the gates low for exactly HICCUP_CLKS clocks. The block then returns to running, with restartReq high for that first running clock only.
- R6: Each overcurrent trip that leads to a hiccup uses one retry. An overcurrent trip that arrives after MAX_RETRIES hiccups have already been used latches the block off instead. The retry count is cleared only by reset.
- R7: Under-voltage is ignored while ssDone is low. With ssDone high, a trip needs the comparator high for UV_FILTER_CLKS consecutive clocks. A shorter burst has no effect on the gates.
- R8: An under-voltage trip always starts a hiccup and never uses a retry. Any number of them never latch the block off.
- R9: otFlag high on any clock sets latchedOff from the next clock, in any state, with both gates low. It takes priority over all other faults.
- R10: latchedOff stays high until rstN is asserted. After reset the block is running, with no blocking, latchedOff low and restartReq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| cycleStb | input | 1 | High on the last clock of each switching period |
| hsReq | input | 1 | Raw high-side request from the modulator |
| ocCmp | input | 1 | Low-side overcurrent comparator |
| uvCmp | input | 1 | Feedback-below-threshold comparator |
| otFlag | input | 1 | Over-temperature flag |
| ssDone | input | 1 | Soft-start has completed |
| hsEn | output | 1 | Gated high-side enable |
| lsEn | output | 1 | Gated low-side enable |
| restartReq | output | 1 | One-clock restart request to the startup sequencer |
| latchedOff | output | 1 | Block is shut down until reset |

## Verification
The hardest state to reach is the latch-off that follows the last permitted overcurrent retry. Getting there takes the full series of hiccups, with the retry count kept across each restart. The stimulus replays a run of OC_TRIP_CNT overcurrent periods, waits out the hiccup, and repeats this until the trip that latches. Between those runs, it sends near-miss patterns: one event fewer than the trip count, and an under-voltage burst one clock shorter than the filter. These show that neither arms a trip. Under-voltage trips are then repeated more times than the retry limit, to show that they never consume retries.

// File: rtl/fault_mgr_pkg.sv
package fault_mgr_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_HICCUP  = 2'd1,
    MODE_LATCHED = 2'd2
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic hiccup;
    logic bumpRetry;
  } ctrlStbT;

  // status from datapath to control
  typedef struct packed {
    logic ocTrip;
    logic uvTrip;
    logic hiccupDone;
    logic retriesUsed;
  } dpStatT;

endpackage

// File: rtl/fault_mgr_dp.sv
module fault_mgr_dp
  import fault_mgr_pkg::*;
#(
  parameter int OC_TRIP_CNT    = 4,
  parameter int UV_FILTER_CLKS = 2000,
  parameter int HICCUP_CLKS    = 4000000,
  parameter int MAX_RETRIES    = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  ctrlStbT stb,
  input  logic    cycleStb,
  input  logic    hsReq,
  input  logic    ocCmp,
  input  logic    uvCmp,
  input  logic    ssDone,
  output dpStatT  stat,
  output logic    hsEn,
  output logic    lsEn
);

  localparam int OCW = $clog2(OC_TRIP_CNT + 1);
  localparam int UVW = $clog2(UV_FILTER_CLKS + 1);
  localparam int HCW = $clog2(HICCUP_CLKS + 1);
  localparam int RTW = $clog2(MAX_RETRIES + 1);
  localparam logic [OCW-1:0] OC_LAST  = OCW'(OC_TRIP_CNT - 1);
  localparam logic [UVW-1:0] UV_LAST  = UVW'(UV_FILTER_CLKS - 1);
  localparam logic [HCW-1:0] HIC_LAST = HCW'(HICCUP_CLKS - 1);
  localparam logic [RTW-1:0] RT_MAX   = RTW'(MAX_RETRIES);

  logic           ocSeen;
  logic           hsBlock;
  logic [OCW-1:0] ocRunCnt;
  logic [UVW-1:0] uvCnt;
  logic [HCW-1:0] hicCnt;
  logic [RTW-1:0] retryCnt;
  logic           periodEvt;
  logic           uvActive;

  assign periodEvt = ocSeen | ocCmp;
  assign uvActive  = ssDone & uvCmp;

  // per-period overcurrent tracking and blanking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocSeen   <= 1'b0;
      hsBlock  <= 1'b0;
      ocRunCnt <= '0;
    end else if (!stb.run) begin
      ocSeen   <= 1'b0;
      hsBlock  <= 1'b0;
      ocRunCnt <= '0;
    end else if (cycleStb) begin
      ocSeen   <= 1'b0;
      hsBlock  <= periodEvt;
      ocRunCnt <= periodEvt ? ocRunCnt + 1'b1 : '0;
    end else begin
      ocSeen   <= periodEvt;
    end
  end

  // under-voltage persistence filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   uvCnt <= '0;
    else if (!stb.run || !uvActive) uvCnt <= '0;
    else                         uvCnt <= uvCnt + 1'b1;
  end

  // hiccup off-time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hicCnt <= '0;
    else if (stb.hiccup) hicCnt <= hicCnt + 1'b1;
    else                 hicCnt <= '0;
  end

  // overcurrent retries used since power-on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              retryCnt <= '0;
    else if (stb.bumpRetry) retryCnt <= retryCnt + 1'b1;
  end

  always_comb begin
    stat.ocTrip      = stb.run & cycleStb & periodEvt & (ocRunCnt == OC_LAST);
    stat.uvTrip      = stb.run & uvActive & (uvCnt == UV_LAST);
    stat.hiccupDone  = stb.hiccup & (hicCnt == HIC_LAST);
    stat.retriesUsed = (retryCnt == RT_MAX);
  end

  assign hsEn = stb.run & hsReq & ~hsBlock;
  assign lsEn = stb.run & ~hsReq;

endmodule

// File: rtl/fault_mgr_ctrl.sv
module fault_mgr_ctrl
  import fault_mgr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    otFlag,
  input  dpStatT  stat,
  output ctrlStbT stb,
  output logic    restartReq,
  output logic    latchedOff
);

  modeT mode;
  modeT nextMode;
  logic restartNext;
  logic bump;

  always_comb begin
    nextMode    = mode;
    restartNext = 1'b0;
    bump        = 1'b0;
    if (otFlag) begin
      nextMode = MODE_LATCHED;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (stat.ocTrip) begin
            if (stat.retriesUsed) begin
              nextMode = MODE_LATCHED;
            end else begin
              nextMode = MODE_HICCUP;
              bump     = 1'b1;
            end
          end else if (stat.uvTrip) begin
            nextMode = MODE_HICCUP;
          end
        end
        MODE_HICCUP: begin
          if (stat.hiccupDone) begin
            nextMode    = MODE_RUN;
            restartNext = 1'b1;
          end
        end
        default: nextMode = MODE_LATCHED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode       <= MODE_RUN;
      restartReq <= 1'b0;
    end else begin
      mode       <= nextMode;
      restartReq <= restartNext;
    end
  end

  always_comb begin
    stb.run       = (mode == MODE_RUN);
    stb.hiccup    = (mode == MODE_HICCUP);
    stb.bumpRetry = bump;
  end

  assign latchedOff = (mode == MODE_LATCHED);

endmodule

// File: rtl/buck_fault_mgr.sv
module buck_fault_mgr
  import fault_mgr_pkg::*;
#(
  parameter int OC_TRIP_CNT    = 4,
  parameter int UV_FILTER_CLKS = 2000,
  parameter int HICCUP_CLKS    = 4000000,
  parameter int MAX_RETRIES    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleStb,
  input  logic hsReq,
  input  logic ocCmp,
  input  logic uvCmp,
  input  logic otFlag,
  input  logic ssDone,
  output logic hsEn,
  output logic lsEn,
  output logic restartReq,
  output logic latchedOff
);

  ctrlStbT strobe;
  dpStatT  status;

  fault_mgr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .otFlag     (otFlag),
    .stat       (status),
    .stb        (strobe),
    .restartReq (restartReq),
    .latchedOff (latchedOff)
  );

  fault_mgr_dp #(
    .OC_TRIP_CNT    (OC_TRIP_CNT),
    .UV_FILTER_CLKS (UV_FILTER_CLKS),
    .HICCUP_CLKS    (HICCUP_CLKS),
    .MAX_RETRIES    (MAX_RETRIES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (strobe),
    .cycleStb (cycleStb),
    .hsReq    (hsReq),
    .ocCmp    (ocCmp),
    .uvCmp    (uvCmp),
    .ssDone   (ssDone),
    .stat     (status),
    .hsEn     (hsEn),
    .lsEn     (lsEn)
  );

endmodule

// File: rtl/fault_mgr_chk.sv
module fault_mgr_chk (
  input logic clk,
  input logic rstN,
  input logic hsReq,
  input logic otFlag,
  input logic runNow,
  input logic hsEn,
  input logic lsEn,
  input logic restartReq,
  input logic latchedOff
);

  // R3: gate enables mutually exclusive
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hsEn && lsEn));

  // R3: gates off outside running
  a_r3_gates_off: assert property (@(posedge clk) disable iff (!rstN)
    !runNow |-> (!hsEn && !lsEn));

  // R2: low side follows inverse request while running
  a_r2_ls_follows: assert property (@(posedge clk) disable iff (!rstN)
    (runNow && !hsReq) |-> lsEn);

  // R5: restart request is a single clock and only when running
  a_r5_restart_single: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq);
  a_r5_restart_runs: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> runNow);

  // R9: over-temperature latches on the next clock
  a_r9_ot_latch: assert property (@(posedge clk) disable iff (!rstN)
    otFlag |=> latchedOff);

  // R10: latched state is sticky
  a_r10_latch_sticky: assert property (@(posedge clk) disable iff (!rstN)
    latchedOff |=> latchedOff);

endmodule

bind buck_fault_mgr fault_mgr_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hsReq      (hsReq),
  .otFlag     (otFlag),
  .runNow     (strobe.run),
  .hsEn       (hsEn),
  .lsEn       (lsEn),
  .restartReq (restartReq),
  .latchedOff (latchedOff)
);

// File: tb/tb_buck_fault_mgr.sv
`timescale 1ns/1ps
module tb_buck_fault_mgr;

  localparam int OCN  = 4;
  localparam int UVN  = 6;
  localparam int HIC  = 20;
  localparam int MAXR = 3;
  localparam int PER  = 8;

  logic clk = 1'b0;
  logic rstN, cycleStb, hsReq, ocCmp, uvCmp, otFlag, ssDone;
  logic hsEn, lsEn, restartReq, latchedOff;

  always #2.5 clk = ~clk;

  buck_fault_mgr #(
    .OC_TRIP_CNT(OCN), .UV_FILTER_CLKS(UVN),
    .HICCUP_CLKS(HIC), .MAX_RETRIES(MAXR)
  ) dut (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .hsReq(hsReq),
    .ocCmp(ocCmp), .uvCmp(uvCmp), .otFlag(otFlag), .ssDone(ssDone),
    .hsEn(hsEn), .lsEn(lsEn), .restartReq(restartReq), .latchedOff(latchedOff)
  );

  // scenario knobs
  int    phase = 0;
  bit    ocOn = 0, uvOn = 0, otOn = 0, ssOn = 0;
  int    ocPhase = 4;
  string curReq = "R10";
  int    vectors = 0, misses = 0;
  bit    finished = 0;

  // behavioural reference: 0 running, 1 off-time, 2 shut down
  int mMode, mSeen, mBlk, mOcRun, mUvRun, mHicT, mTries, mRestart;

  task automatic modelReset();
    mMode = 0; mSeen = 0; mBlk = 0; mOcRun = 0; mUvRun = 0;
    mHicT = 0; mTries = 0; mRestart = 0;
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      int evt;
      mRestart = 0;
      if (otFlag) begin
        mMode = 2;
      end else if (mMode == 0) begin
        evt = (mSeen != 0 || ocCmp) ? 1 : 0;
        if (cycleStb && evt == 1 && mOcRun == OCN - 1) begin
          if (mTries == MAXR) mMode = 2;
          else begin mTries++; mMode = 1; mHicT = 0; end
        end else if (ssDone && uvCmp && mUvRun == UVN - 1) begin
          mMode = 1; mHicT = 0;
        end else begin
          if (cycleStb) begin
            mBlk = evt; mSeen = 0;
            mOcRun = evt ? mOcRun + 1 : 0;
          end else mSeen = evt;
          mUvRun = (ssDone && uvCmp) ? mUvRun + 1 : 0;
        end
        if (mMode != 0) begin mSeen = 0; mBlk = 0; mOcRun = 0; mUvRun = 0; end
      end else if (mMode == 1) begin
        if (mHicT == HIC - 1) begin mMode = 0; mRestart = 1; end
        else mHicT++;
      end
    end
  end

  task automatic compare();
    logic eHs, eLs, eRr, eLo;
    eHs = (mMode == 0) && hsReq && (mBlk == 0);
    eLs = (mMode == 0) && !hsReq;
    eRr = (mRestart != 0);
    eLo = (mMode == 2);
    vectors++;
    if ({hsEn, lsEn, restartReq, latchedOff} !== {eHs, eLs, eRr, eLo}) begin
      misses++;
      $display("FAIL %s t=%0t hs/ls/rr/lo got %b%b%b%b exp %b%b%b%b", curReq, $time,
               hsEn, lsEn, restartReq, latchedOff, eHs, eLs, eRr, eLo);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    hsReq    = rstN && (phase < 3);
    cycleStb = (phase == PER - 1);
    ocCmp    = ocOn && (phase == ocPhase);
    uvCmp    = uvOn;
    otFlag   = otOn;
    ssDone   = ssOn;
    if (!rstN) modelReset();
    #1 compare();
    phase = (phase + 1) % PER;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic periods(input int n);
    ticks(n * PER);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    rstN = 1'b0; cycleStb = 0; hsReq = 0; ocCmp = 0; uvCmp = 0; otFlag = 0; ssDone = 0;
    modelReset();
    curReq = "R10"; ticks(3);
    rstN = 1'b1;    ticks(PER - 3);          // reset state, aligned to period
    curReq = "R2";  periods(3);              // normal switching
    curReq = "R1";  ocOn = 1; ocPhase = 4; periods(1); ocOn = 0; periods(2);
    ocPhase = PER - 1; ocOn = 1; periods(1); ocOn = 0; periods(2);  // event on strobe clock
    curReq = "R4";  ocOn = 1; ocPhase = 2; periods(OCN - 1); ocOn = 0; periods(2); // near miss
    ocOn = 1; periods(OCN); ocOn = 0;        // trip
    curReq = "R5";  ticks(HIC + 10);
    curReq = "R6";
    for (int k = 0; k < MAXR; k++) begin
      ocOn = 1; periods(OCN); ocOn = 0; ticks(HIC + 10);
    end
    ticks(20);                               // latched, stays off
    curReq = "R10"; rstN = 0; tick(); rstN = 1; ticks(PER - 1);
    curReq = "R7";  uvOn = 1; ssOn = 0; ticks(20); uvOn = 0; ssOn = 1;
    uvOn = 1; ticks(UVN - 1); uvOn = 0; ticks(3);
    uvOn = 1; ticks(UVN); uvOn = 0; ticks(HIC + 5);
    curReq = "R8";
    for (int k = 0; k < MAXR + 2; k++) begin
      uvOn = 1; ticks(UVN); uvOn = 0; ticks(HIC + 5);
    end
    curReq = "R9";  uvOn = 1; ticks(UVN); uvOn = 0; ticks(4);
    otOn = 1; tick(); otOn = 0; ticks(HIC + 5);    // during off-time
    rstN = 0; tick(); rstN = 1; ticks(5);
    ocOn = 1; periods(1);
    otOn = 1; tick(); otOn = 0; ocOn = 0; ticks(10); // while running
    curReq = "R10"; rstN = 0; tick(); rstN = 1; periods(2);
    finish();
  end

endmodule